// File: doc/BRIEF.md
# Short Forward Branch Shadow Pairing Unit

This unit sits at decode and issue in a two-lane in-order integer pipeline. Each cycle it is offered two fetched instruction words with their addresses. It looks for one case: a conditional branch whose taken target skips exactly one instruction. When that next instruction is a plain register-writing ALU operation, the branch goes down lane 0 and the skipped "shadow" instruction goes down lane 1, both in the same cycle. They remain two separate instructions.

The pair travels as though the branch were predicted not-taken. In the final stage the branch compare decides the outcome. A taken branch only suppresses the shadow's register write. There is no flush, no redirect and no penalty cycle, so issue never stalls.

When no pair is found, only the first word issues. A lone ALU instruction executes and writes back. A lone branch resolves its condition and writes nothing. The block holds a 32-entry register file, with x0 fixed at zero, and has a combinational peek port for reading it.

Top module: `shadow_pair_issue`

## Requirements
- R1: With `in_valid` high, `issue_count` is 2 when all of these hold: `word0` has opcode 7'b1100011 with a condition code in bits 14:12 of 000, 001, 100, 101, 110 or 111; its B-type immediate equals +8; `word1_valid` is high; `pc1` equals `pc0`+4; and `word1` has opcode 7'b0110011 or 7'b0010011. Otherwise `issue_count` is 1 while `in_valid` is high and 0 while it is low.
- R2: When a branch fails pairing for any reason (an offset other than +8, a shadow of another class such as opcode 7'b0000011, a non-sequential `pc1`, or `word1_valid` low), the branch issues alone and `word1` makes no register write.
- R3: One cycle after a branch issues, `br_resolved` is high and `br_taken` gives the condition on rs1 (bits 19:15) and rs2 (bits 24:20). The codes are: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal.
- R4: If a paired branch is not taken, the shadow's result appears on `wb_en`/`wb_rd`/`wb_data` in that same resolve cycle and is stored in the register file at the following edge.
- R5: If a paired branch is taken, `wb_en` stays low in the resolve cycle and the shadow's destination keeps its old value.
- R6: No flush or stall occurs: every cycle with `in_valid` high accepts at least one word, and a group may follow a taken pair in the very next cycle.
- R7: A write to x0 never takes effect; `wb_en` is never raised for destination 0, and x0 reads as zero.
- R8: Operands are read in the resolve stage and reflect every earlier group, including the group that resolved in the previous cycle. A shadow that reads a branch source or its own destination sees the values from before the pair.
- R9: An unpaired ALU instruction in lane 0 executes add, sub, sll, slt, sltu, xor, srl, sra, or and and, plus their immediate forms. Bit 30 selects sub and sra.
- R10: After reset, every register reads zero and `wb_en` and `br_resolved` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch group offered this cycle |
| word0 | input | 32 | First instruction word |
| word1 | input | 32 | Second instruction word |
| word1_valid | input | 1 | Second word is present |
| pc0 | input | XLEN | Address of word0 |
| pc1 | input | XLEN | Address of word1 |
| issue_count | output | 2 | Words consumed this cycle |
| br_resolved | output | 1 | A branch resolves this cycle |
| br_taken | output | 1 | Outcome of the resolving branch |
| wb_en | output | 1 | Register write this cycle |
| wb_rd | output | 5 | Write destination |
| wb_data | output | XLEN | Write value |
| peek_addr | input | 5 | Register file read address |
| peek_data | output | XLEN | Register file read data |

## Verification
The assertions assume that `in_valid` is low throughout reset. They also assume that nothing is held back from issue: any offered word that is not accepted is offered again later as a fresh group. The bench drives every group at the falling edge and keeps `in_valid` low during reset. It issues groups back to back, with idle cycles only where they are deliberate. This covers each of the six branch conditions in both directions, a shadow that overwrites a branch source, a shadow that targets x0, and every reason pairing can be refused.

// File: rtl/shadow_pair_issue.sv
module shadow_pair_issue #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     word0,
  input  logic [31:0]     word1,
  input  logic            word1_valid,
  input  logic [XLEN-1:0] pc0,
  input  logic [XLEN-1:0] pc1,
  output logic [1:0]      issue_count,
  output logic            br_resolved,
  output logic            br_taken,
  output logic            wb_en,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data,
  input  logic [4:0]      peek_addr,
  output logic [XLEN-1:0] peek_data
);
  localparam int SHW = $clog2(XLEN);
  localparam logic [6:0] OPC_BR  = 7'b1100011;
  localparam logic [6:0] OPC_OP  = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;

  function automatic logic is_br(input logic [31:0] w);
    return (w[6:0] == OPC_BR) && (w[14:13] != 2'b01);
  endfunction

  function automatic logic is_alu(input logic [31:0] w);
    return (w[6:0] == OPC_OP) || (w[6:0] == OPC_IMM);
  endfunction

  function automatic logic [XLEN-1:0] alu(input logic [31:0] w,
                                          input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] rb);
    logic [XLEN-1:0] b;
    logic [SHW-1:0]  sh;
    logic            reg_form, alt;
    reg_form = (w[6:0] == OPC_OP);
    b   = reg_form ? rb : {{(XLEN-12){w[31]}}, w[31:20]};
    sh  = b[SHW-1:0];
    alt = w[30] && (reg_form || w[14:12] == 3'b101);
    case (w[14:12])
      3'b000:  return alt ? a - b : a + b;
      3'b001:  return a << sh;
      3'b010:  return XLEN'($signed(a) < $signed(b));
      3'b011:  return XLEN'(a < b);
      3'b100:  return a ^ b;
      3'b101:  return alt ? XLEN'($signed(a) >>> sh) : a >> sh;
      3'b110:  return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic cond(input logic [2:0] f3,
                                input logic [XLEN-1:0] a,
                                input logic [XLEN-1:0] b);
    case (f3)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      default: return a >= b;
    endcase
  endfunction

  logic            skip_one, pair_ok;
  logic            s_v0, s_pair;
  logic [31:0]     s_w0, s_w1;
  logic [XLEN-1:0] rf [32];

  assign skip_one = {word0[31], word0[7], word0[30:25], word0[11:8]} == 12'h004;
  assign pair_ok  = in_valid && is_br(word0) && skip_one && word1_valid &&
                    (pc1 == pc0 + XLEN'(4)) && is_alu(word1);
  assign issue_count = !in_valid ? 2'd0 : (pair_ok ? 2'd2 : 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_v0   <= 1'b0;
      s_pair <= 1'b0;
      s_w0   <= '0;
      s_w1   <= '0;
    end else begin
      s_v0   <= in_valid;
      s_pair <= pair_ok;
      s_w0   <= word0;
      s_w1   <= word1;
    end
  end

  assign br_resolved = s_v0 && is_br(s_w0);
  assign br_taken    = br_resolved &&
                       cond(s_w0[14:12], rf[s_w0[19:15]], rf[s_w0[24:20]]);

  always_comb begin
    if (s_pair) begin
      wb_rd   = s_w1[11:7];
      wb_data = alu(s_w1, rf[s_w1[19:15]], rf[s_w1[24:20]]);
      wb_en   = !br_taken && (wb_rd != 5'd0);
    end else begin
      wb_rd   = s_w0[11:7];
      wb_data = alu(s_w0, rf[s_w0[19:15]], rf[s_w0[24:20]]);
      wb_en   = s_v0 && is_alu(s_w0) && (wb_rd != 5'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (wb_en) begin
      rf[wb_rd] <= wb_data;
    end
  end

  assign peek_data = rf[peek_addr];
endmodule

module shadow_pair_issue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] issue_count,
  input logic       br_resolved,
  input logic       br_taken,
  input logic       wb_en,
  input logic [4:0] wb_rd
);
  // R1
  pair_resolves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && issue_count == 2'd2) |=> br_resolved);
  // R5
  taken_pair_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && issue_count == 2'd2) && br_taken) |-> !wb_en);
  // R6
  never_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> issue_count != 2'd0);
  // R7
  no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_rd != 5'd0);
  // R3
  taken_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> br_resolved);
endmodule

bind shadow_pair_issue shadow_pair_issue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .issue_count(issue_count),
  .br_resolved(br_resolved), .br_taken(br_taken), .wb_en(wb_en), .wb_rd(wb_rd)
);

// File: tb/tb_shadow_pair_issue.sv
module tb_shadow_pair_issue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] word0 = '0, word1 = '0;
  logic        word1_valid = 1'b0;
  logic [31:0] pc0 = 32'h100, pc1 = 32'h104;
  logic [1:0]  issue_count;
  logic        br_resolved, br_taken, wb_en;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;
  logic [4:0]  peek_addr = '0;
  logic [31:0] peek_data;

  shadow_pair_issue dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] ref_rf [32];
  bit          pend = 0;
  bit          e_br, e_tk, e_wb;
  logic [4:0]  e_rd;
  logic [31:0] e_data;
  string       e_req;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2, rs1,
                                        input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd);
    return {imm, rs1, f3, rd, 7'h13};
  endfunction
  function automatic logic [31:0] enc_b(input int off, input logic [4:0] rs2, rs1,
                                        input logic [2:0] f3);
    logic [12:0] i;
    i = off[12:0];
    return {i[12], i[10:5], rs2, rs1, f3, i[4:1], i[11], 7'h63};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [31:0] w);
    int unsigned a, b;
    int sa, sb;
    bit reg_form;
    reg_form = w[6:0] == 7'h33;
    a = ref_rf[w[19:15]];
    b = reg_form ? ref_rf[w[24:20]] : 32'($signed(w[31:20]));
    sa = a; sb = b;
    case (w[14:12])
      0: return (reg_form && w[30]) ? a - b : a + b;
      1: return a << b[4:0];
      2: return (sa < sb) ? 1 : 0;
      3: return (a < b) ? 1 : 0;
      4: return a ^ b;
      5: return w[30] ? 32'(sa >>> b[4:0]) : a >> b[4:0];
      6: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic bit ref_cond(input logic [31:0] w);
    int unsigned a, b;
    int sa, sb;
    a = ref_rf[w[19:15]]; b = ref_rf[w[24:20]];
    sa = a; sb = b;
    case (w[14:12])
      0: return a == b;
      1: return a != b;
      4: return sa < sb;
      5: return sa >= sb;
      6: return a < b;
      default: return a >= b;
    endcase
  endfunction

  task automatic settle();
    if (pend) begin
      chk(br_resolved == e_br, {e_req, " resolve"}, 32'(br_resolved), 32'(e_br));
      chk(br_taken == e_tk, {e_req, " taken"}, 32'(br_taken), 32'(e_tk));
      chk(wb_en == e_wb, {e_req, " wb_en"}, 32'(wb_en), 32'(e_wb));
      if (e_wb) begin
        chk(wb_rd == e_rd, {e_req, " wb_rd"}, 32'(wb_rd), 32'(e_rd));
        chk(wb_data == e_data, {e_req, " wb_data"}, wb_data, e_data);
        ref_rf[e_rd] = e_data;
      end
      pend = 0;
    end else begin
      chk(!wb_en && !br_resolved, "R6 idle", 32'({wb_en, br_resolved}), 0);
    end
  endtask

  task automatic grp(input logic [31:0] w0, input logic [31:0] w1, input bit w1v,
                     input bit seq, input string req);
    bit isbr, pair, sh_alu;
    int off;
    @(negedge clk);
    settle();
    in_valid = 1; word0 = w0; word1 = w1; word1_valid = w1v;
    pc1 = seq ? pc0 + 4 : pc0 + 12;
    #1;
    isbr = w0[6:0] == 7'h63 && w0[14:12] != 2 && w0[14:12] != 3;
    off = $signed({w0[31], w0[7], w0[30:25], w0[11:8], 1'b0});
    sh_alu = w1[6:0] == 7'h33 || w1[6:0] == 7'h13;
    pair = isbr && off == 8 && w1v && seq && sh_alu;
    chk(issue_count == (pair ? 2'd2 : 2'd1), {req, " issue_count"},
        32'(issue_count), pair ? 2 : 1);
    e_br = isbr;
    e_tk = isbr && ref_cond(w0);
    if (pair) begin
      e_rd = w1[11:7]; e_data = ref_alu(w1); e_wb = !e_tk && e_rd != 0;
    end else if (w0[6:0] == 7'h33 || w0[6:0] == 7'h13) begin
      e_rd = w0[11:7]; e_data = ref_alu(w0); e_wb = e_rd != 0;
    end else begin
      e_rd = 0; e_data = 0; e_wb = 0;
    end
    e_req = req;
    pend = 1;
  endtask

  task automatic idle();
    @(negedge clk);
    settle();
    in_valid = 0;
    #1;
    chk(issue_count == 2'd0, "R1 idle count", 32'(issue_count), 0);
  endtask

  localparam logic [31:0] NOPW = 32'h0000_0013;

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) ref_rf[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!wb_en && !br_resolved, "R10 outputs", 32'({wb_en, br_resolved}), 0);
    for (int r = 0; r < 32; r += 7) begin
      peek_addr = 5'(r); #1;
      chk(peek_data == 0, "R10 reg clear", peek_data, 0);
    end
    rst_n = 1;
    // R9 setup
    grp(enc_i(12'd5, 0, 0, 1), NOPW, 0, 1, "R9 addi x1");
    grp(enc_i(-12'sd3, 0, 0, 2), NOPW, 0, 1, "R9 addi x2");
    grp(enc_i(12'd5, 0, 0, 3), NOPW, 0, 1, "R9 addi x3");
    grp(enc_i(12'd100, 0, 0, 4), NOPW, 0, 1, "R9 addi x4");
    grp(enc_i(12'hfff, 0, 0, 5), NOPW, 0, 1, "R9 addi x5");
    // R3 R4 R5 each condition both ways
    grp(enc_b(8, 3, 1, 0), enc_i(12'd11, 0, 0, 10), 1, 1, "R5 beq taken");
    grp(enc_b(8, 2, 1, 0), enc_i(12'd11, 0, 0, 10), 1, 1, "R4 beq not taken");
    grp(enc_b(8, 3, 1, 1), enc_r(0, 4, 1, 0, 11), 1, 1, "R4 bne not taken");
    grp(enc_b(8, 2, 1, 1), enc_r(7'h20, 4, 1, 0, 11), 1, 1, "R5 bne taken");
    grp(enc_b(8, 1, 2, 4), enc_i(12'd7, 1, 4, 12), 1, 1, "R3 blt taken");
    grp(enc_b(8, 2, 1, 4), enc_r(0, 1, 2, 2, 12), 1, 1, "R4 blt not taken");
    grp(enc_b(8, 2, 1, 5), enc_i(12'd9, 0, 0, 13), 1, 1, "R3 bge taken");
    grp(enc_b(8, 1, 2, 5), enc_i(12'h401, 2, 5, 13), 1, 1, "R4 bge not taken");
    grp(enc_b(8, 5, 1, 6), enc_i(12'd9, 0, 0, 14), 1, 1, "R3 bltu taken");
    grp(enc_b(8, 1, 5, 6), enc_r(0, 5, 1, 3, 14), 1, 1, "R4 bltu not taken");
    grp(enc_b(8, 1, 5, 7), enc_i(12'd9, 0, 0, 15), 1, 1, "R3 bgeu taken");
    grp(enc_b(8, 5, 1, 7), enc_r(0, 1, 1, 1, 15), 1, 1, "R4 bgeu not taken");
    // R8 shadow overwrites a branch source, then back-to-back use
    grp(enc_b(8, 2, 1, 0), enc_r(0, 2, 1, 0, 1), 1, 1, "R8 shadow rewrites x1");
    grp(enc_i(12'd0, 1, 0, 16), NOPW, 0, 1, "R8 back to back read");
    // R7
    grp(enc_b(8, 2, 1, 0), enc_i(12'd7, 0, 0, 0), 1, 1, "R7 shadow to x0");
    // R6 taken pair followed at once
    grp(enc_b(8, 0, 0, 0), enc_i(12'd1, 0, 0, 17), 1, 1, "R6 taken pair");
    grp(enc_i(12'd3, 0, 0, 17), NOPW, 0, 1, "R6 next group");
    // R2 refusals
    grp(enc_b(12, 0, 0, 0), enc_i(12'd1, 0, 0, 18), 1, 1, "R2 offset 12");
    grp(enc_b(-8, 0, 0, 1), enc_i(12'd1, 0, 0, 18), 1, 1, "R2 offset -8");
    grp(enc_b(8, 0, 0, 0), {12'd0, 5'd0, 3'd2, 5'd18, 7'h03}, 1, 1, "R2 load shadow");
    grp(enc_b(8, 0, 0, 0), enc_i(12'd1, 0, 0, 18), 1, 0, "R2 non sequential");
    grp(enc_b(8, 0, 0, 0), enc_i(12'd1, 0, 0, 18), 0, 1, "R2 no second word");
    idle();
    // R9 lane-0 ALU set
    grp(enc_r(0, 2, 4, 6, 19), NOPW, 0, 1, "R9 or");
    grp(enc_r(0, 5, 4, 7, 20), NOPW, 0, 1, "R9 and");
    grp(enc_r(0, 3, 5, 5, 21), NOPW, 0, 1, "R9 srl");
    grp(enc_r(7'h20, 3, 5, 5, 22), NOPW, 0, 1, "R9 sra");
    grp(enc_r(0, 3, 4, 4, 23), NOPW, 0, 1, "R9 xor");
    grp(enc_i(12'd0, 2, 2, 24), NOPW, 0, 1, "R9 slti");
    grp(enc_i(12'd4, 2, 3, 25), NOPW, 0, 1, "R9 sltiu");
    grp(enc_i(12'd3, 4, 1, 26), NOPW, 0, 1, "R9 slli");
    idle();
    @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      peek_addr = 5'(r); #1;
      chk(peek_data == ref_rf[r], r == 0 ? "R7 final x0" : "R8 final regfile",
          peek_data, ref_rf[r]);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule